// File: doc/BRIEF.md
# Serial Management Slave with Basic Control Register

This block is the management end of a 10/100 Ethernet transceiver's two-wire serial interface. The management clock (`mdc`) is its only clock, and it samples the data line on every rising edge. It looks for a frame: a long run of ones, a start pattern, an opcode, a device address and a register number. It acts on the frame only when the device address equals the 5-bit strap `phy_addr`. A write frame loads the basic control register. A read frame returns that register's 16 bits on the data line after a turnaround.

The control register is held as nine flag bits. They are presented as plain level outputs that drive the transceiver: reset, loopback, speed, autonegotiation enable, autonegotiation restart, power down, isolate, duplex and collision test. Reset and restart clear themselves. Every other register number reads as zero and accepts no writes.

The serial line is split into `mdio_in`, which carries the line's value, and the pair `mdio_out`/`mdio_oe`, which goes to an external tri-state pad. There is no stream handshake and no back-pressure, because the controller owns the clock. The slave never stalls a frame. It keeps pace with every bit the controller clocks, and it drives the line only in the cycles listed in R4.

Top module: `mdio_ctrl_slave`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive ones on `mdio_in`, followed by the start bits 0 then 1. A 0 that arrives before 32 ones have been seen restarts the count. A frame with a shorter preamble changes nothing.
- R2: Opcode 10 (first bit 1) selects a read and opcode 01 selects a write. Opcodes 00 and 11 cause no drive and no register change.
- R3: The device address (5 bits, MSB first, after the opcode) must equal `phy_addr`. On a mismatch, `mdio_oe` stays low and the register is unchanged.
- R4: On a matching read, `mdio_oe` stays low during the first turnaround bit. It is high with `mdio_out` = 0 during the second turnaround bit. It then stays high for 16 data bits, MSB first, each changed on a rising `mdc` edge. It is low again from the bit after the last data bit.
- R5: On a matching write, the two turnaround bits are skipped and the 16 data bits (MSB first) are captured. The register, and so the outputs, take the new value on the rising edge that samples the last data bit.
- R6: Register 0 bit map: 15 reset, 14 loopback, 13 speed (1 = 100 Mb/s), 12 autonegotiation enable, 11 power down, 10 isolate, 9 autonegotiation restart, 8 duplex (1 = full), 7 collision test. After `rst_n` the value is 0x3100.
- R7: Bits 6:0 of register 0 always read as 0, whatever was written to them.
- R8: Writing 1 to bit 15 loads the default 0x3100 with bit 15 set. Bit 15 (`ctl_reset`) is then cleared on the next `mdc` edge, so it is high for exactly one cycle.
- R9: Writing 1 to bit 9 raises `ctl_an_restart` for exactly one `mdc` cycle. It then clears, and the other bits keep the written value.
- R10: A read of any register number other than 0 returns 0x0000. Writes to those numbers are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling and driving on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped device address |
| mdio_in | input | 1 | Value of the management data line |
| mdio_out | output | 1 | Data the slave drives on a read |
| mdio_oe | output | 1 | Enable for the line driver |
| ctl_reset | output | 1 | Reset request, one-cycle pulse |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_speed100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| ctl_an_enable | output | 1 | Autonegotiation enable |
| ctl_power_down | output | 1 | Power down |
| ctl_isolate | output | 1 | Isolate from the MAC side |
| ctl_an_restart | output | 1 | Autonegotiation restart, one-cycle pulse |
| ctl_full_duplex | output | 1 | 1 = full duplex |
| ctl_col_test | output | 1 | Collision test |

## Verification
The assertions assume that `phy_addr` is static and that writes arrive no closer together than one frame length. Under that assumption a self-clearing bit is never re-written in the cycle it clears, and the register holds its value between frames. The stimulus keeps both conditions. The strap is tied to one value for the whole run. Every frame carries a full preamble and header of at least 44 cycles. The bench changes `mdio_in` only on falling edges, so the slave's rising-edge sampling always sees a settled line.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

  typedef enum logic [2:0] {
    S_HUNT, S_START, S_HDR, S_TURN, S_READ, S_WTURN, S_WDATA
  } mdio_state_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  // flag order equals register bit order 15 down to 7
  typedef struct packed {
    logic rst;
    logic loopback;
    logic speed100;
    logic an_en;
    logic pdown;
    logic isolate;
    logic an_restart;
    logic full_dup;
    logic col_test;
  } ctl_bits_t;

  localparam int unsigned CTL_W = $bits(ctl_bits_t);
  localparam ctl_bits_t CTL_DEFAULT = 9'b0_0_1_1_0_0_0_1_0;

endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_slave_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_in,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_sel,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_out,
  output logic              mdio_oe
);

  localparam int unsigned HDR_BITS = 2 + 2 * ADDR_W;
  localparam int unsigned CNT_W    = $clog2(PRE_LEN + DATA_W + 1);
  localparam logic [CNT_W-1:0] PRE_FULL = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DAT_END  = CNT_W'(DATA_W);

  mdio_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [ADDR_W-1:0] reg_q;
  logic              out_q, oe_q;

  logic [HDR_BITS-1:0] hdr_w;
  logic [1:0]          hdr_op;
  logic [ADDR_W-1:0]   hdr_addr, hdr_reg;
  logic                hdr_hit;

  assign hdr_w    = {sh_q[HDR_BITS-2:0], mdio_in};
  assign hdr_op   = hdr_w[HDR_BITS-1 -: 2];
  assign hdr_addr = hdr_w[2*ADDR_W-1 -: ADDR_W];
  assign hdr_reg  = hdr_w[ADDR_W-1:0];
  assign hdr_hit  = (hdr_addr == dev_addr);

  assign wr_en    = (state_q == S_WDATA) && (cnt_q == DAT_LAST);
  assign wr_data  = {sh_q[DATA_W-2:0], mdio_in};
  assign reg_sel  = reg_q;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HUNT;
      cnt_q   <= '0;
      sh_q    <= '0;
      reg_q   <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        S_HUNT: begin
          if (mdio_in) begin
            if (cnt_q != PRE_FULL) cnt_q <= cnt_q + 1'b1;
          end else begin
            if (cnt_q == PRE_FULL) state_q <= S_START;
            cnt_q <= '0;
          end
        end
        S_START: begin
          state_q <= mdio_in ? S_HDR : S_HUNT;
          cnt_q   <= '0;
        end
        S_HDR: begin
          sh_q  <= {sh_q[DATA_W-2:0], mdio_in};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == HDR_LAST) begin
            cnt_q <= '0;
            reg_q <= hdr_reg;
            if (hdr_hit && hdr_op == OP_READ)       state_q <= S_TURN;
            else if (hdr_hit && hdr_op == OP_WRITE) state_q <= S_WTURN;
            else                                    state_q <= S_HUNT;
          end
        end
        S_TURN: begin
          oe_q    <= 1'b1;
          out_q   <= 1'b0;
          sh_q    <= rd_data;
          cnt_q   <= '0;
          state_q <= S_READ;
        end
        S_READ: begin
          if (cnt_q == DAT_END) begin
            oe_q    <= 1'b0;
            out_q   <= 1'b0;
            cnt_q   <= '0;
            state_q <= S_HUNT;
          end else begin
            out_q <= sh_q[DATA_W-1];
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_WTURN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q[0]) begin
            cnt_q   <= '0;
            state_q <= S_WDATA;
          end
        end
        S_WDATA: begin
          sh_q  <= {sh_q[DATA_W-2:0], mdio_in};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == DAT_LAST) begin
            cnt_q   <= '0;
            state_q <= S_HUNT;
          end
        end
        default: begin
          state_q <= S_HUNT;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !out_q); // R4
  AST_DRIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |=> oe_q); // R4
  AST_NO_DRIVE_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HDR && cnt_q == HDR_LAST && !hdr_hit) |=> !oe_q); // R3

endmodule

// File: rtl/mdio_ctrl_reg0.sv
module mdio_ctrl_reg0
  import mdio_slave_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_sel,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_flags,
  output logic [DATA_W-1:0] rd_data,
  output ctl_bits_t         ctl
);

  localparam int unsigned RSVD_W = DATA_W - CTL_W;

  ctl_bits_t ctl_q;
  logic      sel_zero;

  assign sel_zero = (reg_sel == '0);
  assign rd_data  = sel_zero ? {ctl_q, {RSVD_W{1'b0}}} : '0;
  assign ctl      = ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_DEFAULT;
    end else if (wr_en && sel_zero) begin
      if (wr_flags[CTL_W-1]) begin
        ctl_q     <= CTL_DEFAULT;
        ctl_q.rst <= 1'b1;
      end else begin
        ctl_q <= ctl_bits_t'(wr_flags);
      end
    end else begin
      ctl_q.rst        <= 1'b0;
      ctl_q.an_restart <= 1'b0;
    end
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.rst && !wr_en) |=> !ctl_q.rst); // R8
  AST_RST_LOADS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.rst && !wr_en) |=> (ctl_q == CTL_DEFAULT)); // R8
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.an_restart && !wr_en) |=> !ctl_q.an_restart); // R9
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({ctl_q.loopback, ctl_q.speed100, ctl_q.an_en, ctl_q.pdown,
                        ctl_q.isolate, ctl_q.full_dup, ctl_q.col_test})); // R10

endmodule

// File: rtl/mdio_ctrl_slave.sv
module mdio_ctrl_slave
  import mdio_slave_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 16
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              ctl_reset,
  output logic              ctl_loopback,
  output logic              ctl_speed100,
  output logic              ctl_an_enable,
  output logic              ctl_power_down,
  output logic              ctl_isolate,
  output logic              ctl_an_restart,
  output logic              ctl_full_duplex,
  output logic              ctl_col_test
);

  logic [ADDR_W-1:0] reg_sel;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  ctl_bits_t         ctl;

  mdio_frame_rx #(.PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .dev_addr(phy_addr),
    .rd_data(rd_data), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  mdio_ctrl_reg0 #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg0 (
    .clk(mdc), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_flags(wr_data[DATA_W-1 -: CTL_W]), .rd_data(rd_data), .ctl(ctl)
  );

  assign ctl_reset       = ctl.rst;
  assign ctl_loopback    = ctl.loopback;
  assign ctl_speed100    = ctl.speed100;
  assign ctl_an_enable   = ctl.an_en;
  assign ctl_power_down  = ctl.pdown;
  assign ctl_isolate     = ctl.isolate;
  assign ctl_an_restart  = ctl.an_restart;
  assign ctl_full_duplex = ctl.full_dup;
  assign ctl_col_test    = ctl.col_test;

endmodule

// File: tb/mdio_ctrl_slave_bench.sv
module mdio_ctrl_slave_bench;

  logic       mdc = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] phy_addr = 5'h0B;
  logic       mdio_in = 1'b1;
  logic       mdio_out, mdio_oe;
  logic       ctl_reset, ctl_loopback, ctl_speed100, ctl_an_enable, ctl_power_down;
  logic       ctl_isolate, ctl_an_restart, ctl_full_duplex, ctl_col_test;

  int  checks = 0;
  int  errors = 0;
  bit  oe_seen;

  always #10 mdc = ~mdc;

  mdio_ctrl_slave u_mdio_ctrl_slave (
    .mdc(mdc), .rst_n(rst_n), .phy_addr(phy_addr), .mdio_in(mdio_in),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .ctl_reset(ctl_reset),
    .ctl_loopback(ctl_loopback), .ctl_speed100(ctl_speed100),
    .ctl_an_enable(ctl_an_enable), .ctl_power_down(ctl_power_down),
    .ctl_isolate(ctl_isolate), .ctl_an_restart(ctl_an_restart),
    .ctl_full_duplex(ctl_full_duplex), .ctl_col_test(ctl_col_test)
  );

  // {is_write, addr, regnum, wdata, expected (read data, or pins after write)}
  localparam logic [42:0] VEC [10] = '{
    {1'b0, 5'h0B, 5'd0,  16'h0000, 16'h3100},
    {1'b1, 5'h0B, 5'd0,  16'h4080, 16'h4080},
    {1'b0, 5'h0B, 5'd0,  16'h0000, 16'h4080},
    {1'b1, 5'h0B, 5'd0,  16'h6D7F, 16'h6D00},
    {1'b0, 5'h0B, 5'd0,  16'h0000, 16'h6D00},
    {1'b1, 5'h0C, 5'd0,  16'h0000, 16'h6D00},
    {1'b0, 5'h0B, 5'd0,  16'h0000, 16'h6D00},
    {1'b1, 5'h0B, 5'd3,  16'hFFFF, 16'h6D00},
    {1'b0, 5'h0B, 5'd3,  16'h0000, 16'h0000},
    {1'b0, 5'h0B, 5'd31, 16'h0000, 16'h0000}
  };

  function automatic string vec_tag(input int idx);
    case (idx)
      0: return "R6";
      1, 2: return "R5";
      3, 4: return "R7";
      5, 6: return "R3";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] pins();
    return {ctl_reset, ctl_loopback, ctl_speed100, ctl_an_enable, ctl_power_down,
            ctl_isolate, ctl_an_restart, ctl_full_duplex, ctl_col_test, 7'b0};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge mdc);
    if (mdio_oe) oe_seen = 1'b1;
    mdio_in = b;
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] a,
                       input logic [4:0] r, input logic [15:0] d,
                       output logic [15:0] rd, output logic ta_ok);
    oe_seen = 1'b0;
    rd = '0;
    ta_ok = 1'b1;
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(a[i]);
    for (int i = 4; i >= 0; i--) send_bit(r[i]);
    if (op == 2'b10) begin
      @(negedge mdc);
      if (mdio_oe) begin ta_ok = 1'b0; oe_seen = 1'b1; end
      mdio_in = 1'b1;
      @(negedge mdc);
      if (mdio_oe) oe_seen = 1'b1;
      if (!(mdio_oe && !mdio_out)) ta_ok = 1'b0;
      for (int i = 0; i < 16; i++) begin
        @(negedge mdc);
        if (mdio_oe) oe_seen = 1'b1;
        rd = {rd[14:0], mdio_oe ? mdio_out : 1'b1};
        if (!mdio_oe) ta_ok = 1'b0;
      end
      @(negedge mdc);
      if (mdio_oe) ta_ok = 1'b0;
    end else begin
      send_bit(1'b1);
      send_bit(1'b0);
      for (int i = 15; i >= 0; i--) send_bit(d[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge mdc);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic        ok;
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    chk("R6 reset pins", pins(), 16'h3100);
    chk("R4 idle release", {15'b0, mdio_oe}, 16'h0);

    // table walk
    for (int v = 0; v < 10; v++) begin
      if (VEC[v][42]) begin
        frame(32, 2'b01, VEC[v][41:37], VEC[v][36:32], VEC[v][31:16], rd, ok);
        @(negedge mdc);
        chk({vec_tag(v), " write"}, pins(), VEC[v][15:0]);
        chk({vec_tag(v), " write no drive"}, {15'b0, oe_seen}, 16'h0);
      end else begin
        frame(32, 2'b10, VEC[v][41:37], VEC[v][36:32], 16'h0, rd, ok);
        chk({vec_tag(v), " read"}, rd, VEC[v][15:0]);
        chk("R4 turnaround shape", {15'b0, ok}, 16'h1);
      end
    end

    // R6: pin map for 0x6D00
    chk("R6 pin map", {ctl_loopback, ctl_speed100, ctl_an_enable, ctl_power_down,
                       ctl_isolate, ctl_full_duplex, ctl_col_test, 9'b0},
        {7'b1101110, 9'b0});

    // R2: undefined opcodes
    frame(32, 2'b11, 5'h0B, 5'd0, 16'h0000, rd, ok);
    @(negedge mdc);
    chk("R2 opcode 11", pins(), 16'h6D00);
    chk("R2 opcode 11 no drive", {15'b0, oe_seen}, 16'h0);
    frame(32, 2'b00, 5'h0B, 5'd0, 16'h0000, rd, ok);
    @(negedge mdc);
    chk("R2 opcode 00", pins(), 16'h6D00);
    chk("R2 opcode 00 no drive", {15'b0, oe_seen}, 16'h0);

    // R1: short preamble is ignored
    frame(31, 2'b01, 5'h0B, 5'd0, 16'h0000, rd, ok);
    @(negedge mdc);
    chk("R1 short preamble", pins(), 16'h6D00);
    frame(32, 2'b01, 5'h0B, 5'd0, 16'h2100, rd, ok);
    @(negedge mdc);
    chk("R1 full preamble", pins(), 16'h2100);

    // R3: mismatched read never drives
    frame(32, 2'b10, 5'h0C, 5'd0, 16'h0, rd, ok);
    chk("R3 mismatch read no drive", {15'b0, oe_seen}, 16'h0);

    // R9: restart pulse
    frame(32, 2'b01, 5'h0B, 5'd0, 16'h6F00, rd, ok);
    @(negedge mdc);
    chk("R9 restart high", {15'b0, ctl_an_restart}, 16'h1);
    @(negedge mdc);
    chk("R9 restart cleared", {15'b0, ctl_an_restart}, 16'h0);
    chk("R9 other bits kept", pins(), 16'h6D00);

    // R8: reset bit loads defaults and self-clears
    frame(32, 2'b01, 5'h0B, 5'd0, 16'hC000, rd, ok);
    @(negedge mdc);
    chk("R8 reset high with defaults", pins(), 16'hB100);
    @(negedge mdc);
    chk("R8 reset cleared", pins(), 16'h3100);
    frame(32, 2'b10, 5'h0B, 5'd0, 16'h0, rd, ok);
    chk("R8 read after reset", rd, 16'h3100);

    // R6: asynchronous reset restores default
    frame(32, 2'b01, 5'h0B, 5'd0, 16'h4000, rd, ok);
    @(negedge mdc);
    rst_n = 1'b0;
    @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    chk("R6 default after rst_n", pins(), 16'h3100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule